// File: doc/BRIEF.md
# Counter Channel with Reload, Capture and Compare

This block is one channel of a multi-channel timer. A down counter advances on a count strobe. It produces a one-cycle terminal-count pulse whenever it would have reached zero; at that point it takes the reload value instead of zero. The reload value sets the division ratio, so the terminal count rate is the strobe rate divided by the reload value. A reload value of zero divides by 2^W.

A capture register can be written by the host. When capture is enabled in the channel's mode word, a gate edge of the selected polarity also copies the live count into it. Each such capture raises a one-cycle event pulse, so that a neighbouring data-port block can refresh any value it has fetched ahead of time.

An optional compare register feeds an equality comparator. Its output is active only while the master-level compare enable is set. The host can read back the reload, capture, mode and compare registers. The counter itself cannot be read or written by the host.

Top module: `counter_group`

## Requirements
- R1: After synchronous reset, the counter, the reload, capture, mode and compare registers, `rd_data_o`, `tc_o`, `alarm_o` and `cap_evt_o` are all zero.
- R2: A host write with `wr_sel_i` = 0 stores `wr_data_i` as the reload value. The same write restarts the counter with that value, which takes priority over a strobe in the same cycle.
- R3: On each cycle with `tick_i` high, the counter moves down by one, unless R2 or R4 applies. A count of 0 becomes all-ones.
- R4: A strobe while the counter holds 1 loads the reload value and drives `tc_o` high for exactly the next cycle. As a result, reload value N gives one pulse every N strobes, and N = 0 gives one pulse every 2^W strobes.
- R5: With `tick_i` low and no reload write, the counter keeps its value.
- R6: Mode bit 0 enables capture, and mode bit 1 selects the edge: 0 for rising, 1 for falling. The gate passes through a two-flop synchronizer. A gate change present before clock edge k is captured at edge k+2. At that edge the capture register takes the counter value held just before that edge, and `cap_evt_o` is high for the following cycle.
- R7: With mode bit 0 clear, gate edges leave the capture register unchanged and `cap_evt_o` low.
- R8: With compare present and `cmp_en_i` high, `alarm_o` is high in the cycle after a cycle in which the counter equals the compare register. `alarm_o` is low whenever `cmp_en_i` was low in the previous cycle.
- R9: `rd_data_o` is registered. It shows, one cycle after `rd_sel_i`, the register selected by that code: 0 reload, 1 capture, 2 mode, 3 compare. Code 3 reads zero when compare is absent. Writes to codes 1, 2 and 3 store `wr_data_i` in that register.
- R10: When a gate capture and a host write to the capture register fall in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count strobe, one count per high cycle |
| gate_i | input | 1 | Asynchronous gate used for captures |
| cmp_en_i | input | 1 | Master-level compare enable |
| wr_en_i | input | 1 | Host register write strobe |
| wr_sel_i | input | 2 | Write target: 0 reload, 1 capture, 2 mode, 3 compare |
| wr_data_i | input | W | Host write data |
| rd_sel_i | input | 2 | Readback select, same codes as writes |
| rd_data_o | output | W | Registered readback data |
| tc_o | output | 1 | Terminal-count pulse |
| alarm_o | output | 1 | Compare-match output |
| cap_evt_o | output | 1 | Pulse after each gate capture |

## Verification
The bench builds the channel with W = 8 and compare present. This makes the zero-reload case (256 strobes per pulse) and the all-ones wrap short enough to run several full periods. The same build also reaches captures at every count value and compare matches. Directed phases cover both edge polarities, capture disabled, and a capture colliding with a host write. A long stretch of random strobes, gate toggles and writes follows. On every clock the outputs are compared against a behavioural model.

// File: rtl/cg_pkg.sv
package cg_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD  = 2'd0,
    SEL_CAPTURE = 2'd1,
    SEL_MODE    = 2'd2,
    SEL_COMPARE = 2'd3
  } cg_sel_e;

  localparam int MODE_CAP_EN = 0;
  localparam int MODE_FALL   = 1;
endpackage

// File: rtl/cg_gate_sync.sv
module cg_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  localparam int TOTAL = STAGES + 1;
  logic [TOTAL-1:0] pipe_q;
  logic             cur, prev;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[TOTAL-2:0], gate_i};
  end

  assign cur    = pipe_q[STAGES-1];
  assign prev   = pipe_q[STAGES];
  assign edge_o = fall_sel_i ? (prev & ~cur) : (cur & ~prev);

  // R6: an edge indication never lasts two cycles in a row
  p_edge_single_r6: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/cg_down_counter.sv
module cg_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         restart_i,
  input  logic [W-1:0] restart_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;
  logic         at_tc;

  assign at_tc = tick_i && (cnt_q == ONE) && !restart_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tc_o  <= 1'b0;
    end else begin
      tc_o <= at_tc;
      if (restart_i)   cnt_q <= restart_val_i;
      else if (at_tc)  cnt_q <= reload_i;
      else if (tick_i) cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;

  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !restart_i && cnt_q == ONE) |=> (cnt_q == $past(reload_i) && tc_o));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !restart_i && cnt_q == '0) |=> (cnt_q == '1));
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == $past(restart_val_i)));
endmodule

// File: rtl/cg_compare.sv
module cg_compare #(
  parameter int W         = 16,
  parameter bit HAS_ALARM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] value_o,
  output logic         match_o
);
  generate
    if (HAS_ALARM) begin : g_cmp
      logic [W-1:0] cmp_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_q   <= '0;
          match_o <= 1'b0;
        end else begin
          match_o <= en_i && (cnt_i == cmp_q);
          if (wr_i) cmp_q <= wr_data_i;
        end
      end
      assign value_o = cmp_q;

      p_enable_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !match_o);
    end else begin : g_nocmp
      logic unused;
      assign unused  = ^{wr_i, wr_data_i, en_i, cnt_i, clk, rst};
      assign value_o = '0;
      assign match_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/counter_group.sv
module counter_group
  import cg_pkg::*;
#(
  parameter int W           = 16,
  parameter bit HAS_ALARM   = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         gate_i,
  input  logic         cmp_en_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [1:0]   rd_sel_i,
  output logic [W-1:0] rd_data_o,
  output logic         tc_o,
  output logic         alarm_o,
  output logic         cap_evt_o
);
  cg_sel_e      wsel, rsel;
  logic [W-1:0] reload_q, hold_q, mode_q, cmp_val, cnt;
  logic         gate_edge, capture;
  logic         wr_reload, wr_hold, wr_mode, wr_cmp;

  assign wsel      = cg_sel_e'(wr_sel_i);
  assign rsel      = cg_sel_e'(rd_sel_i);
  assign wr_reload = wr_en_i && wsel == SEL_RELOAD;
  assign wr_hold   = wr_en_i && wsel == SEL_CAPTURE;
  assign wr_mode   = wr_en_i && wsel == SEL_MODE;
  assign wr_cmp    = wr_en_i && wsel == SEL_COMPARE;

  cg_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .gate_i(gate_i),
    .fall_sel_i(mode_q[MODE_FALL]), .edge_o(gate_edge));

  assign capture = gate_edge && mode_q[MODE_CAP_EN];

  cg_down_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .restart_i(wr_reload), .restart_val_i(wr_data_i),
    .reload_i(reload_q), .cnt_o(cnt), .tc_o(tc_o));

  cg_compare #(.W(W), .HAS_ALARM(HAS_ALARM)) u_cmp (
    .clk(clk), .rst(rst), .wr_i(wr_cmp), .wr_data_i(wr_data_i),
    .en_i(cmp_en_i), .cnt_i(cnt), .value_o(cmp_val), .match_o(alarm_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q  <= '0;
      hold_q    <= '0;
      mode_q    <= '0;
      cap_evt_o <= 1'b0;
      rd_data_o <= '0;
    end else begin
      cap_evt_o <= capture;
      if (wr_reload) reload_q <= wr_data_i;
      if (wr_mode)   mode_q   <= wr_data_i;
      if (capture)      hold_q <= cnt;
      else if (wr_hold) hold_q <= wr_data_i;
      unique case (rsel)
        SEL_RELOAD:  rd_data_o <= reload_q;
        SEL_CAPTURE: rd_data_o <= hold_q;
        SEL_MODE:    rd_data_o <= mode_q;
        default:     rd_data_o <= cmp_val;
      endcase
    end
  end

  // R6 / R10: the capture event reports the counter value sampled at capture
  p_capture_value_r6: assert property (@(posedge clk) disable iff (rst)
    cap_evt_o |-> (hold_q == $past(cnt)));
  p_capture_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (capture && wr_hold) |=> (hold_q == $past(cnt)));
  p_no_capture_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_q[MODE_CAP_EN] |=> !cap_evt_o);
endmodule

// File: tb/test_counter_group.sv
`timescale 1ns/1ps
module test_counter_group;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0, rst = 1'b1;
  logic         tick = 0, gate = 0, cmp_en = 0, wr_en = 0;
  logic [1:0]   wr_sel = 0, rd_sel = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] rd_data;
  logic         tc, alarm, cap_evt;

  int compared = 0, mismatched = 0;
  string phase = "R1";

  counter_group #(.W(W), .HAS_ALARM(1'b1), .SYNC_STAGES(2)) i_counter_group (
    .clk(clk), .rst(rst), .tick_i(tick), .gate_i(gate), .cmp_en_i(cmp_en),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .tc_o(tc), .alarm_o(alarm), .cap_evt_o(cap_evt));

  always #4 clk = ~clk;

  // behavioural reference
  int m_load, m_hold, m_mode, m_cmp, m_cnt;
  int g1, g2, g3;
  int e_rd, e_tc, e_alarm, e_cap;

  always @(posedge clk) begin
    if (rst) begin
      m_load = 0; m_hold = 0; m_mode = 0; m_cmp = 0; m_cnt = 0;
      g1 = 0; g2 = 0; g3 = 0;
      e_rd = 0; e_tc = 0; e_alarm = 0; e_cap = 0;
    end else begin
      bit edge_seen, cap, ldw;
      edge_seen = (m_mode & 2) ? (g3 == 1 && g2 == 0) : (g3 == 0 && g2 == 1);
      cap = edge_seen && (m_mode & 1);
      ldw = wr_en && wr_sel == 0;
      case (rd_sel)
        0: e_rd = m_load;
        1: e_rd = m_hold;
        2: e_rd = m_mode;
        default: e_rd = m_cmp;
      endcase
      e_alarm = cmp_en && (m_cnt == m_cmp);
      e_tc    = tick && (m_cnt == 1) && !ldw;
      e_cap   = cap;
      if (cap) m_hold = m_cnt;
      else if (wr_en && wr_sel == 1) m_hold = wr_data;
      if (ldw) m_cnt = wr_data;
      else if (tick) m_cnt = (m_cnt == 1) ? m_load : ((m_cnt - 1) & MASK);
      if (ldw) m_load = wr_data;
      if (wr_en && wr_sel == 2) m_mode = wr_data;
      if (wr_en && wr_sel == 3) m_cmp = wr_data;
      g3 = g2; g2 = g1; g1 = gate;
    end
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check({phase, "/R9 rd_data"}, rd_data, e_rd);
      check({phase, "/R4 tc"}, tc, e_tc);
      check({phase, "/R8 alarm"}, alarm, e_alarm);
      check({phase, "/R6 cap_evt"}, cap_evt, e_cap);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = W'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_gate(int hi, int lo);
    gate = 1; cycles(hi); gate = 0; cycles(lo);
  endtask

  initial begin
    cycles(3);
    // R1: reset state seen at the ports
    check("R1 rd_data", rd_data, 0);
    check("R1 tc", tc, 0);
    check("R1 alarm", alarm, 0);
    check("R1 cap_evt", cap_evt, 0);
    rst = 0;
    for (int s = 0; s < 4; s++) begin rd_sel = 2'(s); cycles(2); end

    phase = "R2"; wr(0, 5); tick = 1; cycles(17);
    phase = "R5"; tick = 0; cycles(5);
    for (int i = 0; i < 20; i++) begin tick = i[0]; cycles(1); end
    tick = 1; cycles(3); tick = 0;

    phase = "R6"; rd_sel = 1; wr(2, 1); wr(0, 9); tick = 1;
    for (int i = 0; i < 6; i++) pulse_gate(2 + i, 3);
    wr(2, 3);
    for (int i = 0; i < 6; i++) pulse_gate(3, 2 + i);

    phase = "R7"; wr(2, 0); wr(1, 77);
    for (int i = 0; i < 5; i++) pulse_gate(3, 3);

    phase = "R10"; wr(2, 1);
    gate = 1; cycles(2); wr(1, 200); cycles(4); gate = 0; cycles(4);

    phase = "R3"; wr(0, 0); cycles(600);

    phase = "R8"; wr(3, 4); wr(0, 7); cmp_en = 1; rd_sel = 3; cycles(30);
    cmp_en = 0; cycles(15); cmp_en = 1; cycles(15);

    phase = "RND";
    for (int i = 0; i < 4000; i++) begin
      tick = 1'($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 5) == 0) gate = ~gate;
      if ($urandom_range(0, 19) == 0) cmp_en = ~cmp_en;
      rd_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 29) == 0) begin
        wr_en = 1; wr_sel = 2'($urandom_range(0, 3));
        wr_data = W'($urandom_range(0, MASK));
        if (wr_sel == 0) wr_data = W'($urandom_range(0, 12));
        if (wr_sel == 3) wr_data = W'($urandom_range(0, 12));
      end else wr_en = 0;
      cycles(1);
    end
    wr_en = 0; cycles(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule